// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one burst request into the stream of column indices that an SDRAM controller presents on successive clocks. A request carries a start column, a three-bit length code and an ordering bit. From the next cycle on, the block emits one column per clock with a valid flag. It also raises a flag on the final beat. The controller's command logic places each column on the address pins, and the data path uses the last flag to close the transfer.

For bursts of 2, 4 or 8 the column stays inside the aligned block that holds the start column. Only the low one, two or three bits move. Linear order steps those bits upward and wraps inside the block. Interleaved order XORs the beat number into them. The row-length code runs linearly through the whole row and wraps at the row end. It carries on until the stop input ends it, and it never flags a last beat. A request for interleaved order together with the row-length code runs linearly and raises an error flag. A new request may arrive on any clock and replaces the burst in progress.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid_o, col_last_o and mode_err_o are all low.
- R2: When start_i is sampled high with a legal code, col_valid_o is high in the following cycle and col_o equals start_col_i.
- R3: Linear order (ilv_i = 0) with code 001, 010 or 011 (2, 4 or 8 beats) steps the low 1, 2 or 3 column bits by one per beat, modulo the burst size, and leaves the upper bits unchanged.
- R4: Interleaved order (ilv_i = 1) with code 001, 010 or 011 gives beat k the low bits equal to the start's low bits XOR k, with the upper bits unchanged.
- R5: A burst with code 000, 001, 010 or 011 lasts 1, 2, 4 or 8 beats. col_last_o is high on the final beat only, and col_valid_o is low in the cycle after it unless a new burst starts.
- R6: Code 111 steps the full column by one per beat and wraps from the all-ones column to zero. col_last_o stays low for the whole burst.
- R7: When stop_i is sampled high during a burst without start_i, col_valid_o is low in the following cycle.
- R8: A legal start during a burst abandons it, and the next cycle shows the new start column.
- R9: A start with a reserved code (100, 101 or 110) has no effect. An idle block stays idle, and a running burst continues its sequence.
- R10: A start with code 111 and ilv_i = 1 runs in linear order and holds mode_err_o high while that burst is valid. mode_err_o is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst this cycle |
| start_col_i | input | COL_W | First column of the burst |
| bl_code_i | input | 3 | Length code: 000=1, 001=2, 010=4, 011=8, 111=row |
| ilv_i | input | 1 | 0 = linear order, 1 = interleaved order |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column for this beat |
| col_valid_o | output | 1 | col_o carries a beat |
| col_last_o | output | 1 | Final beat of a fixed-length burst |
| mode_err_o | output | 1 | Interleaved row burst ran as linear |

## Verification
The properties assume that start_i, stop_i and the request fields are clean levels sampled on the rising edge. They also assume that the request fields matter only in a cycle where start_i is high. When start and stop arrive together, the properties treat start as the winner and make no claim about stop. The stimulus changes every input only on the falling clock edge and holds request fields steady around each start. It asserts stop only at chosen points inside a running burst, which keeps every sampled combination inside those assumptions.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   typedef enum logic [2:0] {
      LEN_ONE  = 3'b000,
      LEN_TWO  = 3'b001,
      LEN_FOUR = 3'b010,
      LEN_OCT  = 3'b011,
      LEN_ROW  = 3'b111
   } len_code_e;

   // widest aligned block is 2**BLK_LG_MAX columns
   localparam int BLK_LG_MAX = 3;

endpackage

// File: rtl/burst_col_decode.sv
module burst_col_decode
   import burst_col_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [2:0]       code_i,
   output logic             legal_o,
   output logic             row_o,
   output logic [COL_W-1:0] mask_o
);

   logic [1:0] lg;

   always_comb begin
      legal_o = 1'b1;
      row_o   = 1'b0;
      lg      = 2'd0;
      case (code_i)
         LEN_ONE:  lg = 2'd0;
         LEN_TWO:  lg = 2'd1;
         LEN_FOUR: lg = 2'd2;
         LEN_OCT:  lg = 2'd3;
         LEN_ROW:  row_o = 1'b1;
         default:  legal_o = 1'b0;
      endcase
   end

   // mask marks the column bits that move during the burst
   for (genvar b = 0; b < COL_W; b++) begin : g_mask
      if (b < BLK_LG_MAX) begin : g_low
         assign mask_o[b] = row_o | (legal_o & (int'(lg) > b));
      end else begin : g_high
         assign mask_o[b] = row_o;
      end
   end

endmodule

// File: rtl/burst_col_order.sv
module burst_col_order #(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] lin, xored, moved;

   assign lin   = base_i + beat_i;
   assign xored = base_i ^ beat_i;
   assign moved = ilv_i ? xored : lin;
   assign col_o = (base_i & ~mask_i) | (moved & mask_i);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import burst_col_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       bl_code_i,
   input  logic             ilv_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             col_valid_o,
   output logic             col_last_o,
   output logic             mode_err_o
);

   if (COL_W < BLK_LG_MAX) begin : g_bad_width
      $error("burst_col_gen: COL_W must cover the widest aligned block");
   end

   logic             legal, row;
   logic [COL_W-1:0] mask;

   burst_col_decode #(.COL_W(COL_W)) u_dec (
      .code_i  (bl_code_i),
      .legal_o (legal),
      .row_o   (row),
      .mask_o  (mask)
   );

   logic [COL_W-1:0] base_q, mask_q, beat_q;
   logic             ilv_q, row_q, err_q, act_q;
   logic             launch, final_beat;

   assign launch     = start_i & legal;
   assign final_beat = act_q & ~row_q & (beat_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         beat_q <= '0;
         ilv_q  <= 1'b0;
         row_q  <= 1'b0;
         err_q  <= 1'b0;
         act_q  <= 1'b0;
      end else if (launch) begin
         base_q <= start_col_i;
         mask_q <= mask;
         beat_q <= '0;
         ilv_q  <= ilv_i & ~row;
         row_q  <= row;
         err_q  <= ilv_i & row;
         act_q  <= 1'b1;
      end else if (act_q) begin
         if (stop_i || final_beat) begin
            act_q <= 1'b0;
            err_q <= 1'b0;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   burst_col_order #(.COL_W(COL_W)) u_ord (
      .base_i (base_q),
      .mask_i (mask_q),
      .beat_i (beat_q),
      .ilv_i  (ilv_q),
      .col_o  (col_o)
   );

   assign col_valid_o = act_q;
   assign col_last_o  = final_beat;
   assign mode_err_o  = err_q;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [2:0]       bl_code_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             col_valid_o,
   input logic             col_last_o,
   input logic             mode_err_o
);

   logic             ok_code;
   logic [COL_W-1:0] span_q;

   assign ok_code = (bl_code_i inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) span_q <= '0;
      else if (start_i && ok_code) begin
         case (bl_code_i)
            3'b001:  span_q <= COL_W'(1);
            3'b010:  span_q <= COL_W'(3);
            3'b011:  span_q <= COL_W'(7);
            3'b111:  span_q <= '1;
            default: span_q <= '0;
         endcase
      end
   end

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ok_code) |=> (col_valid_o && col_o == $past(start_col_i)));

   // R3
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid_o && !col_last_o && !start_i && !stop_i)
      |=> (col_valid_o && ((col_o & ~span_q) == ($past(col_o) & ~span_q))));

   // R5
   last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_last_o && !start_i) |=> !col_valid_o);

   // R5
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_last_o |-> col_valid_o);

   // R6
   row_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && bl_code_i == 3'b111) |=> !col_last_o);

   // R7
   stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i && col_valid_o) |=> !col_valid_o);

   // R9
   reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !ok_code && !col_valid_o) |=> !col_valid_o);

   // R10
   err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err_o |-> col_valid_o);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .bl_code_i   (bl_code_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .col_valid_o (col_valid_o),
   .col_last_o  (col_last_o),
   .mode_err_o  (mode_err_o)
);

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;

   localparam int CW = 10;
   localparam int NV = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] scol = '0;
   logic [2:0]    code = 3'b000;
   logic          ilv = 1'b0;
   logic          stop = 1'b0;
   logic [CW-1:0] col;
   logic          vld, lst, err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   burst_col_gen #(.COL_W(CW)) u_burst_col_gen (
      .clk (clk), .rst_n (rst_n), .start_i (start), .start_col_i (scol),
      .bl_code_i (code), .ilv_i (ilv), .stop_i (stop),
      .col_o (col), .col_valid_o (vld), .col_last_o (lst), .mode_err_o (err)
   );

   // stimulus and expected column per beat
   localparam logic [CW-1:0] VCOL [NV] = '{10'h0A5, 10'h0A5, 10'h2F3, 10'h2F3, 10'h011, 10'h3FF, 10'h012};
   localparam logic [2:0]    VCODE[NV] = '{3'b011, 3'b011, 3'b010, 3'b010, 3'b001, 3'b000, 3'b001};
   localparam bit            VILV [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
   localparam int            VLEN [NV] = '{8, 8, 4, 4, 2, 1, 2};
   localparam logic [CW-1:0] VEXP [NV][8] = '{
      '{10'd165, 10'd166, 10'd167, 10'd160, 10'd161, 10'd162, 10'd163, 10'd164},
      '{10'd165, 10'd164, 10'd167, 10'd166, 10'd161, 10'd160, 10'd163, 10'd162},
      '{10'd755, 10'd754, 10'd753, 10'd752, 10'd0, 10'd0, 10'd0, 10'd0},
      '{10'd755, 10'd752, 10'd753, 10'd754, 10'd0, 10'd0, 10'd0, 10'd0},
      '{10'd17, 10'd16, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0},
      '{10'd1023, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0},
      '{10'd18, 10'd19, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0}
   };

   task automatic chk(input string req, input bit ev, input logic [CW-1:0] ec,
                      input bit el, input bit ee);
      n_chk++;
      if (vld !== ev || (ev && col !== ec) || lst !== el || err !== ee) begin
         n_bad++;
         $display("FAIL %s: got valid=%b col=%h last=%b err=%b, want valid=%b col=%h last=%b err=%b",
                  req, vld, col, lst, err, ev, ec, el, ee);
      end
   endtask

   // called just after a falling edge; returns one falling edge later
   task automatic launch(input logic [CW-1:0] c, input logic [2:0] k, input bit i);
      start = 1'b1; scol = c; code = k; ilv = i;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic halt();
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", 1'b0, '0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 1'b0, '0, 1'b0, 1'b0);

      for (int v = 0; v < NV; v++) begin
         launch(VCOL[v], VCODE[v], VILV[v]);
         for (int k = 0; k < VLEN[v]; k++) begin
            chk(k == 0 ? "R2" : (VILV[v] ? "R4" : "R3"), 1'b1, VEXP[v][k],
                k == VLEN[v] - 1, 1'b0);
            @(negedge clk);
         end
         chk("R5", 1'b0, '0, 1'b0, 1'b0);
      end

      // R6: row burst wraps at row end, no last, ended by stop (R7)
      launch(10'h3FD, 3'b111, 1'b0);
      chk("R6", 1'b1, 10'h3FD, 1'b0, 1'b0); @(negedge clk);
      chk("R6", 1'b1, 10'h3FE, 1'b0, 1'b0); @(negedge clk);
      chk("R6", 1'b1, 10'h3FF, 1'b0, 1'b0); @(negedge clk);
      chk("R6", 1'b1, 10'h000, 1'b0, 1'b0); @(negedge clk);
      chk("R6", 1'b1, 10'h001, 1'b0, 1'b0);
      halt();
      chk("R7", 1'b0, '0, 1'b0, 1'b0);

      // R10: interleave with row code runs linear and flags error
      launch(10'h005, 3'b111, 1'b1);
      for (int k = 0; k < 5; k++) begin
         chk("R10", 1'b1, CW'(5 + k), 1'b0, 1'b1);
         if (k < 4) @(negedge clk);
      end
      halt();
      chk("R10", 1'b0, '0, 1'b0, 1'b0);

      // R7: stop inside an 8-beat burst
      launch(10'h0A0, 3'b011, 1'b1);
      chk("R2", 1'b1, 10'h0A0, 1'b0, 1'b0);
      halt();
      chk("R7", 1'b0, '0, 1'b0, 1'b0);

      // R8: restart cuts the running burst
      launch(10'h100, 3'b011, 1'b0);
      chk("R8", 1'b1, 10'h100, 1'b0, 1'b0);
      launch(10'h203, 3'b010, 1'b1);
      chk("R8", 1'b1, 10'h203, 1'b0, 1'b0); @(negedge clk);
      chk("R8", 1'b1, 10'h202, 1'b0, 1'b0); @(negedge clk);
      chk("R8", 1'b1, 10'h201, 1'b0, 1'b0); @(negedge clk);
      chk("R8", 1'b1, 10'h200, 1'b1, 1'b0); @(negedge clk);
      chk("R8", 1'b0, '0, 1'b0, 1'b0);

      // R9: reserved code while idle
      launch(10'h155, 3'b100, 1'b0);
      chk("R9", 1'b0, '0, 1'b0, 1'b0);

      // R9: reserved code during a burst
      launch(10'h040, 3'b010, 1'b0);
      chk("R2", 1'b1, 10'h040, 1'b0, 1'b0);
      launch(10'h3FF, 3'b101, 1'b1);
      chk("R9", 1'b1, 10'h041, 1'b0, 1'b0); @(negedge clk);
      chk("R9", 1'b1, 10'h042, 1'b0, 1'b0); @(negedge clk);
      chk("R9", 1'b1, 10'h043, 1'b1, 1'b0); @(negedge clk);
      chk("R9", 1'b0, '0, 1'b0, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got running, want finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule